// File: doc/BRIEF.md
# Grouped Write-Noise Injector

This block sits between a writer and the write port of a content-addressable memory. Each write carries an address and a wide hash word. When injection is enabled, the hash is XORed with a pseudo-random flip mask before it reaches the memory. This models stored-bit errors at a rate that can be configured. The address, the valid strobe and the ready strobe pass straight through with no register and no buffering.

The hash is divided into 64-bit groups. A 128-bit xorshift generator supplies the randomness for every group. Its state starts from the 64-bit seed parameter repeated twice. The next generator output is computed combinationally, so the mask that applies to the write now on the port is already visible in that cycle. The generator steps forward only on a rising clock edge where a write is accepted.

The flip rate is the rational number FLIP_NUM/FLIP_DEN. In each group, one slice of the generator output is compared with a threshold derived from that ratio. If the slice is below the threshold, exactly one bit of the group is inverted. If not, the group passes unchanged. A parameter combination whose hash width is not 64 bits times the group count is rejected at elaboration.

Top module: `wnoise_inject`

## Requirements
- R1: `cam_valid` equals `up_valid`, `up_ready` equals `cam_ready`, and `cam_addr` equals `up_addr` in every cycle, with no register on any of these paths.
- R2: `cam_hash` equals `up_hash` XOR a flip mask. In each 64-bit group `g` (bits `64*g+63 : 64*g`), the mask has at most one bit set.
- R3: After reset, the generator state is `{PRNG_SEED, PRNG_SEED}`, held as the 128-bit value `{x, y, z, w}` with `x` in bits 127:96. Reset reloads this state even in the middle of a run.
- R4: One generator step maps `{x,y,z,w}` to `{y,z,w,w'}`, where `t = x ^ (x<<11)` and `w' = w ^ (w>>19) ^ t ^ (t>>8)`. The mask in any cycle is derived from one step applied to the current state, so the mask for the first write after reset comes from one step of the seed state.
- R5: The state advances by one step on each rising edge where `up_valid` and `cam_ready` are both high. In all other cycles it holds, so the mask stays unchanged while a write is stalled or absent.
- R6: Let `S = 128/N_GROUPS` and `C = S-6`. For group `g`, the slice `r[S*g+S-1 : S*g]` of the stepped value `r` is used. Its low `C` bits are compared with `floor(FLIP_NUM * 2^C / FLIP_DEN)`. If the field is strictly below that value, the mask sets bit `r[S*g+C+5 : S*g+C]` of group `g`; otherwise the group's mask is zero.
- R7: With `FLIP_NUM = 0`, no bit is ever flipped. With `FLIP_NUM >= FLIP_DEN`, every group has exactly one bit flipped on every write.
- R8: With `INJECT_EN = 0`, `cam_hash` equals `up_hash` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Upstream write request valid |
| up_ready | output | 1 | Upstream write ready, taken from the memory side |
| up_addr | input | ADDR_W | Upstream row address |
| up_hash | input | HASH_W | Upstream hash word |
| cam_valid | output | 1 | Write valid toward the memory |
| cam_ready | input | 1 | Memory write ready |
| cam_addr | output | ADDR_W | Row address toward the memory |
| cam_hash | output | HASH_W | Hash after noise injection |

## Verification
All port results are combinational, so they are due in the same cycle the inputs are applied. The only delayed effect is the generator step, which shows up in the mask one rising edge after an accepted write. The bench drives inputs just after a falling edge and samples outputs 1 ns later. It advances its own generator model only for cycles in which it drove both valid and ready high. Each sample is therefore compared against the model state that the next rising edge has not yet changed. Mid-run reset and stalled writes are sampled the same way to confirm that the state reloads or holds.

// File: rtl/wnoise_pkg.sv
package wnoise_pkg;

    localparam int RND_W = 128;

    // One xorshift128 step on {x, y, z, w}, x in the top word.
    function automatic logic [RND_W-1:0] xs128_step(input logic [RND_W-1:0] s);
        logic [31:0] x;
        logic [31:0] y;
        logic [31:0] z;
        logic [31:0] w;
        logic [31:0] t;
        logic [31:0] w_new;
        x     = s[127:96];
        y     = s[95:64];
        z     = s[63:32];
        w     = s[31:0];
        t     = x ^ (x << 11);
        w_new = w ^ (w >> 19) ^ t ^ (t >> 8);
        return {y, z, w, w_new};
    endfunction

endpackage

// File: rtl/wnoise_prng.sv
module wnoise_prng
    import wnoise_pkg::*;
#(
    parameter logic [63:0] PRNG_SEED = 64'h0123_4567_89AB_CDEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [RND_W-1:0] rnd_next
);

    logic [RND_W-1:0] state_q;

    // Look-ahead: the value the state will take on the next accepted write.
    always_comb begin
        rnd_next = xs128_step(state_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= {PRNG_SEED, PRNG_SEED};
        end else if (adv) begin
            state_q <= rnd_next;
        end
    end

endmodule

// File: rtl/wnoise_mask_gen.sv
module wnoise_mask_gen
    import wnoise_pkg::*;
#(
    parameter int N_GROUPS = 2,
    parameter int FLIP_NUM = 1,
    parameter int FLIP_DEN = 16
) (
    input  logic [RND_W-1:0]         rnd,
    output logic [64*N_GROUPS-1:0]   mask
);

    localparam int GRP_W   = 64;
    localparam int IDX_W   = 6;
    localparam int SLICE_W = RND_W / N_GROUPS;
    localparam int CMP_W   = SLICE_W - IDX_W;
    localparam logic [127:0] THRESH =
        (128'(FLIP_NUM) << CMP_W) / 128'(FLIP_DEN);

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        logic [SLICE_W-1:0] slice;
        logic [127:0]       field;
        logic [IDX_W-1:0]   idx;
        logic               hit;

        always_comb begin
            slice = rnd[SLICE_W*g +: SLICE_W];
            field = 128'(slice[CMP_W-1:0]);
            idx   = slice[CMP_W +: IDX_W];
            hit   = (field < THRESH);
            mask[GRP_W*g +: GRP_W] = hit ? (64'd1 << idx) : 64'd0;
        end
    end

endmodule

// File: rtl/wnoise_inject.sv
module wnoise_inject
    import wnoise_pkg::*;
#(
    parameter int          HASH_W    = 128,
    parameter int          ADDR_W    = 12,
    parameter int          N_GROUPS  = 2,
    parameter bit          INJECT_EN = 1'b1,
    parameter int          FLIP_NUM  = 1,
    parameter int          FLIP_DEN  = 16,
    parameter logic [63:0] PRNG_SEED = 64'h0123_4567_89AB_CDEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [HASH_W-1:0] up_hash,
    output logic              cam_valid,
    input  logic              cam_ready,
    output logic [ADDR_W-1:0] cam_addr,
    output logic [HASH_W-1:0] cam_hash
);

    if (HASH_W != 64*N_GROUPS || (RND_W % N_GROUPS) != 0
        || (RND_W / N_GROUPS) < 7 || FLIP_DEN <= 0 || FLIP_NUM < 0) begin : g_bad_cfg
        $error("wnoise_inject: hash must be 64 bits per group, groups must divide 128 with >=7 bits each, rate must be valid");
    end

    // Handshake and address: straight wires.
    assign cam_valid = up_valid;
    assign up_ready  = cam_ready;
    assign cam_addr  = up_addr;

    if (INJECT_EN) begin : g_inject
        logic [RND_W-1:0]  rnd_next;
        logic [HASH_W-1:0] flip_mask;
        logic              accept;

        assign accept = up_valid & cam_ready;

        wnoise_prng #(
            .PRNG_SEED(PRNG_SEED)
        ) u_prng (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv     (accept),
            .rnd_next(rnd_next)
        );

        wnoise_mask_gen #(
            .N_GROUPS(N_GROUPS),
            .FLIP_NUM(FLIP_NUM),
            .FLIP_DEN(FLIP_DEN)
        ) u_mask (
            .rnd (rnd_next),
            .mask(flip_mask)
        );

        assign cam_hash = up_hash ^ flip_mask;
    end else begin : g_bypass
        assign cam_hash = up_hash;
    end

endmodule

// File: rtl/wnoise_inject_chk.sv
module wnoise_inject_chk #(
    parameter int HASH_W    = 128,
    parameter int ADDR_W    = 12,
    parameter int N_GROUPS  = 2,
    parameter bit INJECT_EN = 1'b1,
    parameter int FLIP_NUM  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_valid,
    input logic              up_ready,
    input logic [ADDR_W-1:0] up_addr,
    input logic [HASH_W-1:0] up_hash,
    input logic              cam_valid,
    input logic              cam_ready,
    input logic [ADDR_W-1:0] cam_addr,
    input logic [HASH_W-1:0] cam_hash
);

    logic [HASH_W-1:0] seen_mask;
    assign seen_mask = cam_hash ^ up_hash;

    // R1: handshake and address pass through
    a_r1_valid_pass: assert property (@(posedge clk) disable iff (!rst_n)
        cam_valid == up_valid);
    a_r1_ready_pass: assert property (@(posedge clk) disable iff (!rst_n)
        up_ready == cam_ready);
    a_r1_addr_pass: assert property (@(posedge clk) disable iff (!rst_n)
        cam_addr == up_addr);

    // R2: at most one flipped bit per 64-bit group
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp_chk
        a_r2_one_flip: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(seen_mask[64*g +: 64]) <= 1);
    end

    // R5: no accepted write -> mask unchanged on the next cycle
    a_r5_hold_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_valid && cam_ready) |=> $stable(seen_mask));

    if (FLIP_NUM == 0) begin : g_zero_chk
        // R7: zero rate never flips
        a_r7_zero_rate: assert property (@(posedge clk) disable iff (!rst_n)
            cam_hash == up_hash);
    end

    if (!INJECT_EN) begin : g_byp_chk
        // R8: bypass leaves hash untouched
        a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
            cam_hash == up_hash);
    end

endmodule

bind wnoise_inject wnoise_inject_chk #(
    .HASH_W   (HASH_W),
    .ADDR_W   (ADDR_W),
    .N_GROUPS (N_GROUPS),
    .INJECT_EN(INJECT_EN),
    .FLIP_NUM (FLIP_NUM)
) u_chk (.*);

// File: tb/wnoise_inject_tb.sv
module wnoise_inject_tb;

    localparam int          HW   = 128;
    localparam int          AW   = 12;
    localparam logic [63:0] SEED = 64'hDEAD_BEEF_0BAD_F00D;
    localparam int          NUM  = 3;
    localparam int          DEN  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_valid = 1'b0;
    logic          cam_ready = 1'b0;
    logic [AW-1:0] up_addr = '0;
    logic [HW-1:0] up_hash = '0;

    logic          up_ready, cam_valid;
    logic [AW-1:0] cam_addr;
    logic [HW-1:0] cam_hash;
    logic [HW-1:0] hash_zero, hash_full, hash_byp;
    logic          rdy_z, rdy_f, rdy_b, val_z, val_f, val_b;
    logic [AW-1:0] adr_z, adr_f, adr_b;

    int n_run = 0;
    int n_fail = 0;
    int n_flips = 0;
    bit done = 1'b0;
    logic [127:0] model;

    always #2 clk = ~clk;

    wnoise_inject #(.HASH_W(HW), .ADDR_W(AW), .N_GROUPS(2), .INJECT_EN(1'b1),
                    .FLIP_NUM(NUM), .FLIP_DEN(DEN), .PRNG_SEED(SEED)) u_dut (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
        .up_addr(up_addr), .up_hash(up_hash), .cam_valid(cam_valid),
        .cam_ready(cam_ready), .cam_addr(cam_addr), .cam_hash(cam_hash));

    wnoise_inject #(.HASH_W(HW), .ADDR_W(AW), .N_GROUPS(2), .INJECT_EN(1'b1),
                    .FLIP_NUM(0), .FLIP_DEN(DEN), .PRNG_SEED(SEED)) u_dut_zero (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(rdy_z),
        .up_addr(up_addr), .up_hash(up_hash), .cam_valid(val_z),
        .cam_ready(cam_ready), .cam_addr(adr_z), .cam_hash(hash_zero));

    wnoise_inject #(.HASH_W(HW), .ADDR_W(AW), .N_GROUPS(2), .INJECT_EN(1'b1),
                    .FLIP_NUM(9), .FLIP_DEN(DEN), .PRNG_SEED(SEED)) u_dut_full (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(rdy_f),
        .up_addr(up_addr), .up_hash(up_hash), .cam_valid(val_f),
        .cam_ready(cam_ready), .cam_addr(adr_f), .cam_hash(hash_full));

    wnoise_inject #(.HASH_W(HW), .ADDR_W(AW), .N_GROUPS(2), .INJECT_EN(1'b0),
                    .FLIP_NUM(NUM), .FLIP_DEN(DEN), .PRNG_SEED(SEED)) u_dut_byp (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(rdy_b),
        .up_addr(up_addr), .up_hash(up_hash), .cam_valid(val_b),
        .cam_ready(cam_ready), .cam_addr(adr_b), .cam_hash(hash_byp));

    function automatic logic [127:0] tb_step(input logic [127:0] s);
        logic [31:0] t, wn;
        t  = s[127:96] ^ (s[127:96] << 11);
        wn = s[31:0] ^ (s[31:0] >> 19) ^ t ^ (t >> 8);
        return {s[95:64], s[63:32], s[31:0], wn};
    endfunction

    function automatic logic [127:0] tb_mask(input logic [127:0] s, input int num, input int den);
        logic [127:0] r, m, thr, fld;
        r   = tb_step(s);
        m   = '0;
        thr = (128'(num) << 58) / 128'(den);
        for (int g = 0; g < 2; g++) begin
            fld = 128'(r[64*g +: 58]);
            if (fld < thr) m[64*g + int'(r[64*g+58 +: 6])] = 1'b1;
        end
        return m;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Drive after falling edge, sample 1 ns later, advance model at the rising edge.
    task automatic cycle(input bit v, input bit r, input logic [AW-1:0] a, input logic [HW-1:0] h);
        logic [127:0] em, ef;
        @(negedge clk);
        up_valid  = v;
        cam_ready = r;
        up_addr   = a;
        up_hash   = h;
        #1;
        em = tb_mask(model, NUM, DEN);
        ef = tb_mask(model, 9, DEN);
        chk(cam_valid == v && up_ready == r && cam_addr == a, "R1",
            {cam_valid, up_ready, 116'(cam_addr)}, {v, r, 116'(a)});
        chk(cam_hash == (h ^ em), "R6", cam_hash, h ^ em);
        chk($countones(cam_hash[63:0] ^ h[63:0]) <= 1 && $countones(cam_hash[127:64] ^ h[127:64]) <= 1,
            "R2", cam_hash ^ h, em);
        chk(hash_zero == h, "R7", hash_zero, h);
        chk($countones(hash_full[63:0] ^ h[63:0]) == 1 && $countones(hash_full[127:64] ^ h[127:64]) == 1
            && hash_full == (h ^ ef), "R7", hash_full, h ^ ef);
        chk(hash_byp == h, "R8", hash_byp, h);
        if (em != '0) n_flips++;
        if (v && r) model = tb_step(model);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] first_mask, stall_mask;
        void'($urandom(32'd4242));
        model = {SEED, SEED};
        up_hash = {4{32'hA5A5_5A5A}};
        #9;
        // Reset state (R3, R4): outputs idle, mask from one step of the seed state.
        chk(cam_valid == 1'b0, "R1", 128'(cam_valid), 128'd0);
        first_mask = tb_mask({SEED, SEED}, NUM, DEN);
        chk(cam_hash == (up_hash ^ first_mask), "R3", cam_hash ^ up_hash, first_mask);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: first accepted write uses the first step.
        cycle(1'b1, 1'b1, 12'h001, {4{32'h0000_FFFF}});

        // R5: stalled write, mask must hold across cycles.
        stall_mask = tb_mask(model, NUM, DEN);
        for (int i = 0; i < 5; i++) begin
            cycle(1'b1, 1'b0, 12'h3FF, '1);
            chk((cam_hash ^ up_hash) == stall_mask, "R5", cam_hash ^ up_hash, stall_mask);
        end
        for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, 12'h000, '0);
        cycle(1'b1, 1'b1, 12'hFFF, '0);

        // Random traffic.
        for (int i = 0; i < 3000; i++) begin
            cycle(1'($urandom), 1'($urandom), AW'($urandom),
                  {$urandom, $urandom, $urandom, $urandom});
        end

        // R3: reset mid-run reloads the seed state.
        @(negedge clk);
        rst_n = 1'b0;
        up_valid = 1'b0;
        #1;
        model = {SEED, SEED};
        chk((cam_hash ^ up_hash) == first_mask, "R3", cam_hash ^ up_hash, first_mask);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 200; i++) begin
            cycle(1'($urandom), 1'($urandom), AW'($urandom),
                  {$urandom, $urandom, $urandom, $urandom});
        end

        // R6: the chosen rate must actually produce flips.
        chk(n_flips > 0, "R6", 128'(n_flips), 128'd1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule